// File: doc/BRIEF.md
# Segment-Offset Physical Address Generator

This block forms a 20-bit physical address from a 16-bit segment base and a 16-bit offset. It keeps four 16-bit segment registers (code, data, stack, extra). The address is the chosen base shifted left by four bits plus the offset. Because the shift is four bits, every base lies on a 16-byte paragraph boundary. Each base opens a 64 KiB window into a 1 MiB space, and many segment:offset pairs alias onto the same byte.

Each request carries an access kind. The kind picks a default segment. An optional override can name another segment. The extra segment may serve data but never instruction fetches or stack accesses. Such an override is flagged as illegal, and the default segment is used in its place. The result is registered and appears one clock after the request. Segment registers are written through a simple write port.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset, `out_valid`, `out_addr` and `out_illegal` are 0, and all four segment registers hold 0.
- R2: A request sampled at a rising edge with `req_valid`=1 gives `out_valid`=1 and `out_addr` = (segment << 4) + `req_off`, taken modulo 2^20, after that same edge.
- R3: The low four bits of `out_addr` always equal the low four bits of the offset of the request behind it (paragraph-aligned bases).
- R4: With `ovr_en`=0, `req_kind` selects the segment as follows: 0 = instruction fetch → code, 1 = data → data, 2 = stack → stack, 3 = string destination → extra.
- R5: With `ovr_en`=1, `ovr_sel` names the segment (0 code, 1 data, 2 stack, 3 extra), and `out_illegal` is 0, except in the case covered by R6.
- R6: An override to extra (`ovr_sel`=3) on a fetch (kind 0) or a stack access (kind 2) sets `out_illegal`=1, and the address is formed from that kind's default segment.
- R7: Sums above 0xFFFFF wrap modulo 2^20. For example, FFFF:FFFF gives 0x0FFEF.
- R8: The pairs 1DDD:0100, 1DED:0000 and 1DCD:0200 all produce 0x1DED0.
- R9: `wr_en`=1 loads `wr_val` into the register named by `wr_sel` (same encoding as `ovr_sel`). A request in the same cycle still uses the old value; the new value applies from the next cycle.
- R10: In a cycle after which `req_valid` was 0, `out_valid` is 0, and `out_addr` and `out_illegal` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Segment register write strobe |
| wr_sel | input | 2 | Segment register to write (0 code, 1 data, 2 stack, 3 extra) |
| wr_val | input | 16 | Value to write |
| req_valid | input | 1 | Address request strobe |
| req_kind | input | 2 | Access kind (0 fetch, 1 data, 2 stack, 3 string destination) |
| ovr_en | input | 1 | Use `ovr_sel` instead of the default segment |
| ovr_sel | input | 2 | Override segment |
| req_off | input | 16 | Offset within the segment |
| out_valid | output | 1 | Registered result valid |
| out_addr | output | 20 | Registered physical address |
| out_illegal | output | 1 | Registered illegal-override flag |

## Verification
Every address and illegal flag is due exactly one rising edge after its request. Segment writes take effect one edge after the write strobe, so a request in the same cycle still sees the old value. The driver applies inputs at the falling edge and pushes the expected result into a queue. The monitor pops that result at the next falling edge, half a cycle after the capturing edge. Idle behaviour is checked one falling edge after a cycle with no request: at that point the result must be marked invalid and must keep its previous value.

// File: rtl/seg_pkg.sv
package seg_pkg;
    localparam int NUM_SEG = 4;

    typedef enum logic [1:0] {
        SEG_CODE  = 2'd0,
        SEG_DATA  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_EXTRA = 2'd3
    } seg_id_e;

    typedef enum logic [1:0] {
        ACC_FETCH  = 2'd0,
        ACC_DATA   = 2'd1,
        ACC_STACK  = 2'd2,
        ACC_STRDST = 2'd3
    } acc_kind_e;
endpackage

// File: rtl/seg_bank.sv
module seg_bank #(
    parameter int SEG_W = 16,
    parameter int NSEG  = seg_pkg::NUM_SEG,
    localparam int SEL_W = $clog2(NSEG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [SEG_W-1:0] wr_val,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [SEG_W-1:0] rd_val
);
    logic [SEG_W-1:0] bank_d [NSEG];
    logic [SEG_W-1:0] bank_q [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_entry
        always_comb begin
            bank_d[g] = bank_q[g];
            if (wr_en && wr_sel == SEL_W'(g)) begin
                bank_d[g] = wr_val;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank_q[g] <= '0;
            end else begin
                bank_q[g] <= bank_d[g];
            end
        end
    end

    assign rd_val = bank_q[rd_sel];
endmodule

// File: rtl/seg_select.sv
module seg_select
    import seg_pkg::*;
(
    input  logic [1:0] kind,
    input  logic       ovr_en,
    input  logic [1:0] ovr_sel,
    output logic [1:0] sel,
    output logic       illegal
);
    seg_id_e dflt;

    always_comb begin
        unique case (acc_kind_e'(kind))
            ACC_FETCH:  dflt = SEG_CODE;
            ACC_DATA:   dflt = SEG_DATA;
            ACC_STACK:  dflt = SEG_STACK;
            default:    dflt = SEG_EXTRA;
        endcase
    end

    always_comb begin
        sel     = dflt;
        illegal = 1'b0;
        if (ovr_en) begin
            if (seg_id_e'(ovr_sel) == SEG_EXTRA &&
                (acc_kind_e'(kind) == ACC_FETCH || acc_kind_e'(kind) == ACC_STACK)) begin
                illegal = 1'b1;
            end else begin
                sel = ovr_sel;
            end
        end
    end
endmodule

// File: rtl/seg_adder.sv
module seg_adder #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    localparam int ADDR_W = SEG_W + SHIFT
) (
    input  logic [SEG_W-1:0]  base,
    input  logic [OFF_W-1:0]  off,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] base_ext;
    logic [ADDR_W-1:0] off_ext;

    assign base_ext = {base, {SHIFT{1'b0}}};
    assign off_ext  = ADDR_W'(off);
    assign addr     = base_ext + off_ext;
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    localparam int ADDR_W = SEG_W + SHIFT,
    localparam int SEL_W  = $clog2(seg_pkg::NUM_SEG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [SEG_W-1:0]  wr_val,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic              ovr_en,
    input  logic [SEL_W-1:0]  ovr_sel,
    input  logic [OFF_W-1:0]  req_off,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_illegal
);
    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic              illegal;
    } res_t;

    res_t res_d, res_q;

    logic [SEL_W-1:0]  pick;
    logic              bad;
    logic [SEG_W-1:0]  base;
    logic [ADDR_W-1:0] sum;

    seg_select u_select (
        .kind    (req_kind),
        .ovr_en  (ovr_en),
        .ovr_sel (ovr_sel),
        .sel     (pick),
        .illegal (bad)
    );

    seg_bank #(.SEG_W(SEG_W), .NSEG(seg_pkg::NUM_SEG)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_sel (wr_sel),
        .wr_val (wr_val),
        .rd_sel (pick),
        .rd_val (base)
    );

    seg_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_adder (
        .base (base),
        .off  (req_off),
        .addr (sum)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = req_valid;
        if (req_valid) begin
            res_d.addr    = sum;
            res_d.illegal = bad;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid   = res_q.valid;
    assign out_addr    = res_q.addr;
    assign out_illegal = res_q.illegal;
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
    parameter int SHIFT  = 4,
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_kind,
    input logic              ovr_en,
    input logic [1:0]        ovr_sel,
    input logic [SHIFT-1:0]  req_off_lo,
    input logic              out_valid,
    input logic [ADDR_W-1:0] out_addr,
    input logic              out_illegal
);
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_clear_R1: assert (!out_valid && !out_illegal && out_addr == '0);
        end
    end

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    assert_paragraph_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_addr[SHIFT-1:0] == $past(req_off_lo));

    assert_extra_flagged_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ovr_en && ovr_sel == 2'd3 && (req_kind == 2'd0 || req_kind == 2'd2))
        |=> out_illegal);

    assert_flag_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !(ovr_en && ovr_sel == 2'd3 && (req_kind == 2'd0 || req_kind == 2'd2)))
        |=> !out_illegal);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && $stable(out_addr) && $stable(out_illegal)));
endmodule

bind seg_addr_gen seg_addr_gen_chk #(.SHIFT(SHIFT), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_kind    (req_kind),
    .ovr_en      (ovr_en),
    .ovr_sel     (ovr_sel),
    .req_off_lo  (req_off[SHIFT-1:0]),
    .out_valid   (out_valid),
    .out_addr    (out_addr),
    .out_illegal (out_illegal)
);

// File: tb/test_seg_addr_gen.sv
module test_seg_addr_gen;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_val = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic        ovr_en = 1'b0;
    logic [1:0]  ovr_sel = '0;
    logic [15:0] req_off = '0;
    logic        out_valid;
    logic [19:0] out_addr;
    logic        out_illegal;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [15:0] mirror [4];
    logic [20:0] exp_q [$];
    logic [3:0]  lo_q [$];
    string       tag_q [$];
    logic [19:0] last_addr = '0;
    logic        last_ill = 1'b0;

    seg_addr_gen i_seg_addr_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_val(wr_val),
        .req_valid(req_valid), .req_kind(req_kind), .ovr_en(ovr_en), .ovr_sel(ovr_sel),
        .req_off(req_off), .out_valid(out_valid), .out_addr(out_addr), .out_illegal(out_illegal)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
        logic [20:0] t;
        t = {1'b0, s, 4'h0} + {5'h0, o};
        return t[19:0];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drives one request (and optionally a write in the same cycle), pushes expectation.
    task automatic issue(input string tag, input logic [1:0] kind, input logic oe,
                         input logic [1:0] os, input logic [15:0] off,
                         input logic we = 1'b0, input logic [1:0] ws = '0,
                         input logic [15:0] wv = '0);
        logic [1:0] dflt;
        logic [1:0] use_sel;
        logic       ill;
        dflt = kind;
        ill = oe && os == 2'd3 && (kind == 2'd0 || kind == 2'd2);
        use_sel = (oe && !ill) ? os : dflt;
        exp_q.push_back({ill, phys(mirror[use_sel], off)});
        lo_q.push_back(off[3:0]);
        tag_q.push_back(tag);
        req_valid = 1'b1; req_kind = kind; ovr_en = oe; ovr_sel = os; req_off = off;
        wr_en = we; wr_sel = ws; wr_val = wv;
        @(negedge clk);
        if (we) mirror[ws] = wv;
        req_valid = 1'b0; ovr_en = 1'b0; wr_en = 1'b0;
    endtask

    task automatic write_seg(input logic [1:0] s, input logic [15:0] v);
        wr_en = 1'b1; wr_sel = s; wr_val = v;
        @(negedge clk);
        mirror[s] = v;
        wr_en = 1'b0;
    endtask

    // Monitor: pops one expectation for every valid result.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected valid", 32'(out_valid), 32'd0);
            end else begin
                logic [20:0] e;
                logic [3:0]  lo;
                string       t;
                e = exp_q.pop_front();
                lo = lo_q.pop_front();
                t = tag_q.pop_front();
                check({t, " addr"}, 32'(out_addr), 32'(e[19:0]));
                check({t, " illegal"}, 32'(out_illegal), 32'(e[20]));
                check("R3 low nibble", 32'(out_addr[3:0]), 32'(lo));
                last_addr = e[19:0];
                last_ill = e[20];
            end
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) mirror[i] = '0;
        repeat (3) @(negedge clk);
        check("R1 valid", 32'(out_valid), 32'd0);
        check("R1 addr", 32'(out_addr), 32'd0);
        check("R1 illegal", 32'(out_illegal), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        issue("R1 data seg zero", 2'd1, 1'b0, 2'd0, 16'h1234);
        issue("R1 extra seg zero", 2'd3, 1'b0, 2'd0, 16'h00A5);

        write_seg(2'd0, 16'h1DDD);
        write_seg(2'd1, 16'h1DED);
        write_seg(2'd2, 16'h1DCD);
        write_seg(2'd3, 16'hF000);

        issue("R8 R4 fetch code", 2'd0, 1'b0, 2'd0, 16'h0100);
        issue("R8 R4 data", 2'd1, 1'b0, 2'd0, 16'h0000);
        issue("R8 R4 stack", 2'd2, 1'b0, 2'd0, 16'h0200);
        issue("R4 strdst extra", 2'd3, 1'b0, 2'd0, 16'h0ABC);
        issue("R2 R4 data", 2'd1, 1'b0, 2'd0, 16'h7F37);

        issue("R5 data ovr code", 2'd1, 1'b1, 2'd0, 16'h0013);
        issue("R5 strdst ovr stack", 2'd3, 1'b1, 2'd2, 16'h0042);
        issue("R5 fetch ovr data", 2'd0, 1'b1, 2'd1, 16'h0009);
        issue("R5 data ovr extra", 2'd1, 1'b1, 2'd3, 16'h1111);

        issue("R6 fetch ovr extra", 2'd0, 1'b1, 2'd3, 16'h0005);
        issue("R6 stack ovr extra", 2'd2, 1'b1, 2'd3, 16'hABCD);

        write_seg(2'd3, 16'hFFFF);
        issue("R7 wrap top", 2'd3, 1'b0, 2'd0, 16'hFFFF);
        issue("R7 wrap zero", 2'd1, 1'b1, 2'd3, 16'h0010);

        issue("R9 same cycle old", 2'd1, 1'b0, 2'd0, 16'h0020, 1'b1, 2'd1, 16'h4000);
        issue("R9 next cycle new", 2'd1, 1'b0, 2'd0, 16'h0020);

        @(negedge clk);
        @(negedge clk);
        check("R10 idle valid", 32'(out_valid), 32'd0);
        check("R10 idle addr hold", 32'(out_addr), 32'(last_addr));
        check("R10 idle illegal hold", 32'(out_illegal), 32'(last_ill));
        check("R2 queue drained", 32'(exp_q.size()), 32'd0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule